// File: doc/BRIEF.md
# Bus Cycle Wait-State and Ready Controller

This block stretches each bus cycle according to the settings of the address region that the cycle falls in. A decoder upstream supplies a region-hit vector and a separate hit for the on-chip register block. Configuration inputs give each region three things: a wait-count field, a bit that says whether external ready is needed, and a bit that takes the region out of the decision altogether. The block latches the chosen settings when the bus sequencer starts a cycle. It then walks the cycle through its phases: idle, T1, T2, T3, zero or more inserted wait cycles (TW), and T4. The bus sequencer takes the current phase and a wait indication from it.

The wait count always runs out before external ready can end the cycle. When ready is required, it is first sampled in the first wait cycle, or in T3 if no waits are programmed. If ready arrives after that first sample, the block inserts one more wait after the cycle where ready was seen, and then goes to T4. Ready comes from two inputs, ORed together: a synchronous one, and an asynchronous one that first passes through a two-flop synchronizer. When several regions hit at once, the lowest-index region wins. A flag is raised if the hitting regions disagree on their settings.

Top module: `wsr_ctrl`

## Requirements
- R1: Phase codes: IDLE=0, T1=1, T2=2, T3=3, TW=4, T4=5. After reset the phase is IDLE and bus_wait and mismatch are low. A cycle runs T1, T2, T3, then zero or more TW, then T4. After T4 the phase returns to IDLE, or goes straight to T1 if cyc_start is high in T4. bus_wait is high exactly in TW.
- R2: A region whose bit is clear in WIDE_MASK takes its wait count from bits [1:0] of its field, giving 0 to 3 waits. Bit 2 of its field is ignored. Region i's field is cfg_wait[3i+2:3i].
- R3: A region whose bit is set in WIDE_MASK maps field codes 0–3 to 0–3 waits, and codes 4, 5, 6 and 7 to 5, 7, 9 and 15 waits.
- R4: When the selected ready-required bit (cfg_rdy_req[i]) is clear, the cycle has exactly the programmed number of TW, whatever the ready inputs do. When it is set, the cycle never has fewer TW than programmed.
- R5: With ready required, if ready is high at the first sample point, the cycle has exactly the programmed number of TW. The first sample point is the first TW, or T3 when zero waits are programmed.
- R6: With ready required, if ready is first seen in TW number k and that TW is not the first sample point, the cycle has max(N, k+1) TW, where N is the programmed count.
- R7: async_rdy is used only after a two-flop synchronizer, so it counts two clocks later than sync_rdy would. The two ready sources are ORed together.
- R8: A hit on a region whose cfg_addr_mode bit is set is ignored. With no live hit the cycle uses zero waits and no ready.
- R9: A hit on the register block forces zero waits and no ready. mismatch is raised if any live region hit has different settings.
- R10: With several live hits, the lowest index sets the waits and the ready need. mismatch is raised when any live hit has different settings. mismatch is latched at the start of a cycle and held until the next start.
- R11: cyc_start is ignored in T1, T2, T3 and TW.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cyc_start | input | 1 | Start a bus cycle (taken in IDLE or T4) |
| region_hit | input | NREG | Region-hit vector from the address decoder |
| regblk_hit | input | 1 | Cycle targets the on-chip register block |
| cfg_wait | input | 3*NREG | Per-region wait field, region i at [3i+2:3i] |
| cfg_rdy_req | input | NREG | Per-region external-ready-required bit |
| cfg_addr_mode | input | NREG | Per-region bit: pin in address-output mode, region ignored |
| async_rdy | input | 1 | Asynchronous active-high ready |
| sync_rdy | input | 1 | Synchronous active-high ready |
| phase | output | 3 | Current cycle phase code |
| bus_wait | output | 1 | High during inserted wait cycles |
| mismatch | output | 1 | Hitting regions disagree on settings |

## Verification
The critical case is when late ready and the programmed wait count run out in the same wait cycle. This happens when ready is first seen in TW number N and N is at least 2. Ready and the count both end there, and the extra wait that late ready calls for must still be inserted. Directed cycles place ready exactly at slot N, one slot before it and one slot after it, using both ready inputs. Random cycles spread the ready slot and the wait codes across this boundary as well. Each case is judged by comparing the TW count seen at the phase output with max(N, k+1), computed in the bench.

// File: rtl/wsr_pkg.sv
package wsr_pkg;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_e;

    typedef struct packed {
        logic [3:0] waits;
        logic       rdy_req;
    } rgn_cfg_t;

    // Three-bit wait code: linear below four, then a sparse upper set.
    function automatic logic [3:0] wide_waits(input logic [2:0] code);
        logic [3:0] n;
        case (code)
            3'd4:    n = 4'd5;
            3'd5:    n = 4'd7;
            3'd6:    n = 4'd9;
            3'd7:    n = 4'd15;
            default: n = {2'b00, code[1:0]};
        endcase
        return n;
    endfunction

endpackage

// File: rtl/wsr_rdy_sync.sv
module wsr_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_rdy,
    input  logic sync_rdy,
    output logic rdy_any
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], async_rdy};
        end
    end

    assign rdy_any = chain_q[STAGES-1] | sync_rdy;
endmodule

// File: rtl/wsr_region_sel.sv
module wsr_region_sel
    import wsr_pkg::*;
#(
    parameter int               NREG      = 8,
    parameter logic [NREG-1:0]  WIDE_MASK = 8'h0F
) (
    input  logic [NREG-1:0]   region_hit,
    input  logic              regblk_hit,
    input  logic [3*NREG-1:0] cfg_wait,
    input  logic [NREG-1:0]   cfg_rdy_req,
    input  logic [NREG-1:0]   cfg_addr_mode,
    output rgn_cfg_t          sel_cfg,
    output logic              sel_mm
);
    rgn_cfg_t        eff [NREG];
    logic [NREG-1:0] live;

    for (genvar i = 0; i < NREG; i++) begin : g_rgn
        logic [2:0] field;
        assign field = cfg_wait[3*i +: 3];
        assign live[i] = region_hit[i] & ~cfg_addr_mode[i];
        if (WIDE_MASK[i]) begin : g_wide
            assign eff[i].waits = wide_waits(field);
        end else begin : g_narrow
            assign eff[i].waits = {2'b00, field[1:0]};
        end
        assign eff[i].rdy_req = cfg_rdy_req[i];
    end

    always_comb begin
        logic found;
        found   = 1'b0;
        sel_cfg = '0;
        for (int i = 0; i < NREG; i++) begin
            if (live[i] && !found) begin
                sel_cfg = eff[i];
                found   = 1'b1;
            end
        end
        if (regblk_hit) begin
            sel_cfg = '0;
        end
        sel_mm = 1'b0;
        for (int i = 0; i < NREG; i++) begin
            if (live[i] && (eff[i] != sel_cfg)) begin
                sel_mm = 1'b1;
            end
        end
    end
endmodule

// File: rtl/wsr_fsm.sv
module wsr_fsm
    import wsr_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cyc_start,
    input  rgn_cfg_t   sel_cfg,
    input  logic       sel_mm,
    input  logic       rdy_any,
    output logic [2:0] phase,
    output logic       bus_wait,
    output logic       mismatch,
    output logic [3:0] lat_waits,
    output logic       lat_req
);
    localparam logic [CNT_W-1:0] K_MAX = {CNT_W{1'b1}};

    phase_e           state_q, state_d;
    logic [3:0]       waits_q;
    logic             req_q;
    logic             mm_q;
    logic [CNT_W-1:0] k_q;
    logic             ok_q;

    logic [CNT_W:0]   k_now;
    logic             on_time;
    logic             take_start;
    logic             tw_leave;

    assign k_now      = {1'b0, k_q} + (CNT_W+1)'(1);
    assign on_time    = (k_now == (CNT_W+1)'(1)) && (waits_q != 4'd0);
    assign take_start = cyc_start && ((state_q == PH_IDLE) || (state_q == PH_T4));
    assign tw_leave   = (k_now >= (CNT_W+1)'(waits_q))
                        && (!req_q || ok_q || (rdy_any && on_time));

    // State register and per-cycle latched settings
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            waits_q <= '0;
            req_q   <= 1'b0;
            mm_q    <= 1'b0;
            k_q     <= '0;
            ok_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            if (take_start) begin
                waits_q <= sel_cfg.waits;
                req_q   <= sel_cfg.rdy_req;
                mm_q    <= sel_mm;
                k_q     <= '0;
                ok_q    <= 1'b0;
            end else if (state_q == PH_TW) begin
                if (k_q != K_MAX) begin
                    k_q <= k_q + CNT_W'(1);
                end
                if (req_q && rdy_any) begin
                    ok_q <= 1'b1;
                end
            end
        end
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_IDLE: if (take_start) state_d = PH_T1;
            PH_T1:   state_d = PH_T2;
            PH_T2:   state_d = PH_T3;
            PH_T3: begin
                if ((waits_q == 4'd0) && (!req_q || rdy_any)) begin
                    state_d = PH_T4;
                end else begin
                    state_d = PH_TW;
                end
            end
            PH_TW:   if (tw_leave) state_d = PH_T4;
            PH_T4:   state_d = take_start ? PH_T1 : PH_IDLE;
            default: state_d = PH_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        phase     = state_q;
        bus_wait  = (state_q == PH_TW);
        mismatch  = mm_q;
        lat_waits = waits_q;
        lat_req   = req_q;
    end
endmodule

// File: rtl/wsr_ctrl.sv
module wsr_ctrl
    import wsr_pkg::*;
#(
    parameter int              NREG        = 8,
    parameter logic [NREG-1:0] WIDE_MASK   = 8'h0F,
    parameter int              SYNC_STAGES = 2,
    parameter int              CNT_W       = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_start,
    input  logic [NREG-1:0]   region_hit,
    input  logic              regblk_hit,
    input  logic [3*NREG-1:0] cfg_wait,
    input  logic [NREG-1:0]   cfg_rdy_req,
    input  logic [NREG-1:0]   cfg_addr_mode,
    input  logic              async_rdy,
    input  logic              sync_rdy,
    output logic [2:0]        phase,
    output logic              bus_wait,
    output logic              mismatch
);
    rgn_cfg_t   sel_cfg;
    logic       sel_mm;
    logic       rdy_any;
    logic [3:0] lat_waits;
    logic       lat_req;

    wsr_rdy_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .async_rdy (async_rdy),
        .sync_rdy  (sync_rdy),
        .rdy_any   (rdy_any)
    );

    wsr_region_sel #(.NREG(NREG), .WIDE_MASK(WIDE_MASK)) u_sel (
        .region_hit    (region_hit),
        .regblk_hit    (regblk_hit),
        .cfg_wait      (cfg_wait),
        .cfg_rdy_req   (cfg_rdy_req),
        .cfg_addr_mode (cfg_addr_mode),
        .sel_cfg       (sel_cfg),
        .sel_mm        (sel_mm)
    );

    wsr_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .cyc_start (cyc_start),
        .sel_cfg   (sel_cfg),
        .sel_mm    (sel_mm),
        .rdy_any   (rdy_any),
        .phase     (phase),
        .bus_wait  (bus_wait),
        .mismatch  (mismatch),
        .lat_waits (lat_waits),
        .lat_req   (lat_req)
    );
endmodule

// File: rtl/wsr_ctrl_chk.sv
module wsr_ctrl_chk #(
    parameter int CNT_W = 6
) (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] phase,
    input logic       mismatch,
    input logic [3:0] lat_waits,
    input logic       lat_req
);
    logic [CNT_W-1:0] tw_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tw_cnt <= '0;
        end else if (phase == 3'd1) begin
            tw_cnt <= '0;
        end else if ((phase == 3'd4) && (tw_cnt != {CNT_W{1'b1}})) begin
            tw_cnt <= tw_cnt + CNT_W'(1);
        end
    end

    p_t1_to_t2_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd1) |=> (phase == 3'd2));

    p_t2_to_t3_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd2) |=> (phase == 3'd3));

    p_t4_exit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd5) |=> ((phase == 3'd0) || (phase == 3'd1)));

    p_waits_complete_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == 3'd5) |-> (tw_cnt >= CNT_W'(lat_waits)));

    p_noready_exact_r4: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == 3'd5) && !lat_req) |-> (tw_cnt == CNT_W'(lat_waits)));

    p_mm_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == 3'd2) || (phase == 3'd3) || (phase == 3'd4) || (phase == 3'd5))
        |-> $stable(mismatch));
endmodule

bind wsr_ctrl wsr_ctrl_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .phase     (phase),
    .mismatch  (mismatch),
    .lat_waits (lat_waits),
    .lat_req   (lat_req)
);

// File: tb/wsr_ctrl_test.sv
module wsr_ctrl_test;
    localparam int NREG = 8;
    localparam logic [7:0] WIDE = 8'h0F;
    localparam int P_IDLE = 0, P_T1 = 1, P_T2 = 2, P_T3 = 3, P_TW = 4, P_T4 = 5;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_start = 1'b0;
    logic [7:0]  region_hit = '0;
    logic        regblk_hit = 1'b0;
    logic [23:0] cfg_wait = '0;
    logic [7:0]  cfg_rdy_req = '0;
    logic [7:0]  cfg_addr_mode = '0;
    logic        async_rdy = 1'b0;
    logic        sync_rdy = 1'b0;
    logic [2:0]  phase;
    logic        bus_wait;
    logic        mismatch;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    wsr_ctrl uut (
        .clk(clk), .rst_n(rst_n), .cyc_start(cyc_start), .region_hit(region_hit),
        .regblk_hit(regblk_hit), .cfg_wait(cfg_wait), .cfg_rdy_req(cfg_rdy_req),
        .cfg_addr_mode(cfg_addr_mode), .async_rdy(async_rdy), .sync_rdy(sync_rdy),
        .phase(phase), .bus_wait(bus_wait), .mismatch(mismatch)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int dec_wait(input int idx, input bit [2:0] f);
        if (!WIDE[idx]) return int'(f[1:0]);
        case (f)
            3'd4: return 5;
            3'd5: return 7;
            3'd6: return 9;
            3'd7: return 15;
            default: return int'(f);
        endcase
    endfunction

    function automatic void model(input bit [7:0] hit, input bit rb, input bit [23:0] w,
                                  input bit [7:0] rq, input bit [7:0] am,
                                  output int n, output bit req, output bit mm);
        bit found = 1'b0;
        n = 0; req = 1'b0; mm = 1'b0;
        if (!rb) begin
            for (int i = 0; i < NREG; i++) begin
                if (hit[i] && !am[i] && !found) begin
                    n = dec_wait(i, w[3*i +: 3]); req = rq[i]; found = 1'b1;
                end
            end
        end
        for (int i = 0; i < NREG; i++) begin
            if (hit[i] && !am[i] && ((dec_wait(i, w[3*i +: 3]) != n) || (rq[i] != req)))
                mm = 1'b1;
        end
    endfunction

    // r = ready slot: 0 is T3, k is the k-th wait cycle
    function automatic int exp_waits(input int n, input bit req, input int r);
        if (!req) return n;
        if (n == 0) return (r == 0) ? 0 : r + 1;
        if (r <= 1) return n;
        return (n > r + 1) ? n : r + 1;
    endfunction

    // src: bit0 drives sync_rdy, bit1 drives async_rdy
    task automatic run_txn(input string tag, input bit [7:0] hit, input bit rb,
                           input bit [23:0] w, input bit [7:0] rq, input bit [7:0] am,
                           input int r, input int src, input int gap, input bit junk);
        int n; bit req; bit mm; int tw; int bw_bad; int seq_bad; int ew;
        repeat (gap) begin
            @(negedge clk);
            cyc_start = 1'b0; sync_rdy = 1'b0; async_rdy = 1'b0;
        end
        region_hit = hit; regblk_hit = rb; cfg_wait = w; cfg_rdy_req = rq; cfg_addr_mode = am;
        cyc_start = 1'b1; sync_rdy = 1'b0; async_rdy = 1'b0;
        model(hit, rb, w, rq, am, n, req, mm);
        ew = exp_waits(n, req, r);
        tw = 0; bw_bad = 0; seq_bad = 0;
        for (int i = 0; i < 80; i++) begin
            @(negedge clk);
            cyc_start = junk && (i >= 1) && (int'(phase) != P_T4) && ($urandom % 2 == 1);
            if (int'(phase) == P_T4) cyc_start = 1'b0;
            if (i >= 1) begin
                region_hit = 8'($urandom); cfg_wait = 24'($urandom);
            end
            sync_rdy  = src[0] && (i >= 2 + r);
            async_rdy = src[1] && (i >= r);
            if (bus_wait != (int'(phase) == P_TW)) bw_bad++;
            if (i == 0 && int'(phase) != P_T1) seq_bad++;
            if (i == 1 && int'(phase) != P_T2) seq_bad++;
            if (i == 1) check({tag, " R10 mismatch"}, int'(mismatch), int'(mm));
            if (i >= 3 && int'(phase) != P_TW && int'(phase) != P_T4) seq_bad++;
            if (int'(phase) == P_TW) tw++;
            if (int'(phase) == P_T4) break;
        end
        check({tag, " R1 phase order"}, seq_bad, 0);
        check({tag, " R1 bus_wait"}, bw_bad, 0);
        check({tag, " wait count"}, tw, ew);
        cyc_start = 1'b0;
    endtask

    function automatic bit [23:0] put(input bit [23:0] v, input int idx, input bit [2:0] f);
        bit [23:0] t = v;
        t[3*idx +: 3] = f;
        return t;
    endfunction

    initial begin
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 reset phase", int'(phase), P_IDLE);
        check("R1 reset bus_wait", int'(bus_wait), 0);
        check("R1 reset mismatch", int'(mismatch), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle hold", int'(phase), P_IDLE);

        // R2 narrow region, bit 2 ignored
        run_txn("R2 narrow", 8'h20, 0, put('0, 5, 3'b110), '0, '0, 0, 0, 3, 0);
        run_txn("R2 narrow3", 8'h40, 0, put('0, 6, 3'b111), '0, '0, 0, 0, 3, 0);
        // R3 every wide code
        for (int c = 0; c < 8; c++)
            run_txn("R3 wide", 8'h02, 0, put('0, 1, 3'(c)), '0, '0, 0, 0, 3, 0);
        // R4 ready ignored when not required; long waits complete first
        run_txn("R4 noreq", 8'h10, 0, put('0, 4, 3'd3), '0, '0, 0, 1, 3, 0);
        run_txn("R4 noreq0", 8'h10, 0, '0, '0, '0, 9, 0, 3, 0);
        run_txn("R4 long", 8'h01, 0, put('0, 0, 3'd7), 8'h01, '0, 5, 1, 3, 0);
        // R5 ready on time
        run_txn("R5 n2r1", 8'h01, 0, put('0, 0, 3'd2), 8'h01, '0, 1, 1, 3, 0);
        run_txn("R5 n2r0", 8'h01, 0, put('0, 0, 3'd2), 8'h01, '0, 0, 1, 3, 0);
        run_txn("R5 n0r0", 8'h01, 0, '0, 8'h01, '0, 0, 1, 3, 0);
        // R6 late ready, including ready at slot N
        run_txn("R6 n2r2", 8'h01, 0, put('0, 0, 3'd2), 8'h01, '0, 2, 1, 3, 0);
        run_txn("R6 n2r3", 8'h01, 0, put('0, 0, 3'd2), 8'h01, '0, 3, 1, 3, 0);
        run_txn("R6 n3r3", 8'h01, 0, put('0, 0, 3'd3), 8'h01, '0, 3, 3, 3, 0);
        run_txn("R6 n0r4", 8'h01, 0, '0, 8'h01, '0, 4, 1, 3, 0);
        // R7 asynchronous ready through the synchronizer
        run_txn("R7 async late", 8'h02, 0, put('0, 1, 3'd1), 8'h02, '0, 3, 2, 3, 0);
        run_txn("R7 async ontime", 8'h02, 0, put('0, 1, 3'd2), 8'h02, '0, 1, 2, 3, 0);
        // R8 address-mode region and no hit
        run_txn("R8 amode", 8'h04, 0, put('0, 2, 3'd3), 8'h04, 8'h04, 0, 0, 3, 0);
        run_txn("R8 nohit", 8'h00, 0, 24'hFFFFFF, 8'hFF, '0, 0, 0, 3, 0);
        // R9 register block overrides
        run_txn("R9 regblk", 8'h01, 1, put('0, 0, 3'd3), '0, '0, 0, 0, 3, 0);
        // R10 multiple hits
        run_txn("R10 same", 8'h42, 0, put(put('0, 1, 3'd2), 6, 3'd2), '0, '0, 0, 0, 3, 0);
        run_txn("R10 diff", 8'h42, 0, put(put('0, 1, 3'd5), 6, 3'd1), '0, '0, 0, 0, 3, 0);
        // R11 start ignored mid-cycle; R1 back-to-back start from T4
        run_txn("R11 junk", 8'h01, 0, put('0, 0, 3'd6), '0, '0, 0, 0, 3, 1);
        run_txn("R1 chain", 8'h08, 0, put('0, 3, 3'd1), 8'h08, '0, 2, 1, 0, 0);
        run_txn("R1 chain2", 8'h08, 0, put('0, 3, 3'd2), '0, '0, 0, 0, 0, 0);

        // Constrained random mix
        for (int t = 0; t < 300; t++) begin
            bit [7:0] h; bit [7:0] rq; bit [7:0] am; int src; int r;
            case ($urandom % 4)
                0: h = 8'($urandom);
                1: h = 8'h00;
                default: h = 8'(1 << ($urandom % 8));
            endcase
            rq = 8'($urandom); am = ($urandom % 4 == 0) ? 8'($urandom) : 8'h00;
            src = 1 + int'($urandom % 3);
            r = int'($urandom % 13);
            run_txn("RND", h, ($urandom % 8 == 0), 24'($urandom), rq, am, r, src, 3,
                    ($urandom % 4 == 0));
        end

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule